// File: doc/BRIEF.md
# Single-Bus Microstep Control Sequencer

This block is the hardwired control unit of a processor whose registers all share one internal bus. A step register walks through the microsteps of a register-load instruction. For each step, a decoder raises the strobes that put one register on the bus and latch the bus into others. It also raises the strobes that make the ALU form the bus value plus a fixed increment, and that issue a memory read.

Every instruction starts with the same three fetch steps:

- The program counter is copied to the memory address register. In the same step its incremented value is captured in a temporary register.
- The temporary value is written back to the program counter while memory is read.
- After memory reports ready, the memory data register is moved to the instruction register.

The two addressing-mode bits of the freshly loaded instruction then pick the operand steps. An immediate operand is copied straight from the instruction register. A direct operand takes one more memory read. An indirect operand takes a pointer read followed by an operand read.

Each memory-read step stalls while memory is not ready. During such a stall the step register holds, and only the read request stays high. The final step of each instruction raises a one-cycle completion pulse, and the sequence restarts at step 1.

Top module: `bus_step_sequencer`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to step 1. While reset is high every output strobe is low. The first cycle after reset is a step-1 cycle.
- R2: Step 1 raises pc_drv, mar_ld, alu_inc and tmp_ld together.
- R3: Step 2 raises tmp_drv, pc_ld and mem_rd together.
- R4: Step 3 keeps mem_rd high. In the cycle where mem_ready is high it raises mdr_drv and ir_ld. This happens exactly once per instruction.
- R5: In a wait step (steps 3, 6 and 7) with mem_ready low, mem_rd is the only strobe raised and the step does not advance. Step 5 also raises mem_rd alone.
- R6: Mode 2'b00 (immediate) performs step 4 as ir_drv with dst_ld and instr_done. The instruction is 4 steps long.
- R7: Mode 2'b01 (direct) performs step 4 as ir_drv with mar_ld and step 5 as a read. Step 6 waits for ready, then raises mdr_drv, dst_ld and instr_done. The instruction is 6 steps long.
- R8: Mode 2'b10 (indirect) runs steps 4 and 5 as in direct mode. Step 6, on ready, moves MDR into MAR with mdr_drv and mar_ld. Step 7 holds mem_rd, waits for ready, then raises mdr_drv, dst_ld and instr_done. The instruction is 7 steps long, with MAR loaded three times.
- R9: Mode 2'b11 is a no-operation. Step 4 raises only instr_done, and dst_ld is never raised.
- R10: At most one of pc_drv, tmp_drv, mdr_drv and ir_drv is high in any cycle.
- R11: instr_done is high for exactly one cycle, and the following cycle is a step-1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Addressing-mode bits taken from the instruction register |
| mem_ready | input | 1 | Memory has data for the pending read |
| pc_drv | output | 1 | Program counter drives the bus |
| tmp_drv | output | 1 | Temporary register drives the bus |
| mdr_drv | output | 1 | Memory data register drives the bus |
| ir_drv | output | 1 | Instruction register operand/address field drives the bus |
| pc_ld | output | 1 | Program counter loads from the bus |
| mar_ld | output | 1 | Memory address register loads from the bus |
| tmp_ld | output | 1 | Temporary register loads the ALU result |
| ir_ld | output | 1 | Instruction register loads from the bus |
| dst_ld | output | 1 | Destination general register loads from the bus |
| alu_inc | output | 1 | ALU adds the fixed increment to the bus value |
| mem_rd | output | 1 | Memory read request |
| instr_done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The assertions check the cycle-local rules on every cycle: a single bus driver, a frozen step register with only the read request during a stall, the fetch transfer on ready, the pointer hand-off in indirect mode, and the one-cycle completion pulse followed by step 1. What only the bench scenarios can show is the whole-instruction shape. That shape covers the order in which registers drive the bus for each mode, the cycle count per mode for several memory latencies, how many times MAR and the destination are loaded, and recovery from a reset issued in the middle of a stall.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int MODE_W = 2;
  localparam int STEP_W = 3;

  localparam logic [MODE_W-1:0] M_IMM = 2'b00;
  localparam logic [MODE_W-1:0] M_DIR = 2'b01;
  localparam logic [MODE_W-1:0] M_IND = 2'b10;

  typedef enum logic [STEP_W-1:0] {
    ST1 = 3'd0, ST2 = 3'd1, ST3 = 3'd2, ST4 = 3'd3,
    ST5 = 3'd4, ST6 = 3'd5, ST7 = 3'd6
  } step_e;

  typedef struct packed {
    logic pc_drv;
    logic tmp_drv;
    logic mdr_drv;
    logic ir_drv;
    logic pc_ld;
    logic mar_ld;
    logic tmp_ld;
    logic ir_ld;
    logic dst_ld;
    logic alu_inc;
    logic mem_rd;
    logic done;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/bss_step_counter.sv
module bss_step_counter
  import bss_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  done,
  output step_e step
);
  always_ff @(posedge clk) begin
    if (rst)       step <= ST1;
    else if (done) step <= ST1;
    else if (!hold) step <= step_e'(step + 3'd1);
  end
endmodule

// File: rtl/bss_ctrl_decode.sv
module bss_ctrl_decode
  import bss_pkg::*;
(
  input  logic              rst,
  input  step_e             step,
  input  logic [MODE_W-1:0] mode,
  input  logic              mem_ready,
  output ctrl_t             c
);
  always_comb begin
    c = '0;
    if (!rst) begin
      case (step)
        ST1: begin
          c.pc_drv  = 1'b1;
          c.mar_ld  = 1'b1;
          c.alu_inc = 1'b1;
          c.tmp_ld  = 1'b1;
        end
        ST2: begin
          c.tmp_drv = 1'b1;
          c.pc_ld   = 1'b1;
          c.mem_rd  = 1'b1;
        end
        ST3: begin
          c.mem_rd = 1'b1;
          if (mem_ready) begin
            c.mdr_drv = 1'b1;
            c.ir_ld   = 1'b1;
          end else begin
            c.hold = 1'b1;
          end
        end
        ST4: begin
          case (mode)
            M_IMM: begin
              c.ir_drv = 1'b1;
              c.dst_ld = 1'b1;
              c.done   = 1'b1;
            end
            M_DIR, M_IND: begin
              c.ir_drv = 1'b1;
              c.mar_ld = 1'b1;
            end
            default: c.done = 1'b1;
          endcase
        end
        ST5: c.mem_rd = 1'b1;
        ST6: begin
          c.mem_rd = 1'b1;
          if (mem_ready) begin
            c.mdr_drv = 1'b1;
            if (mode == M_IND) begin
              c.mar_ld = 1'b1;
            end else begin
              c.dst_ld = 1'b1;
              c.done   = 1'b1;
            end
          end else begin
            c.hold = 1'b1;
          end
        end
        ST7: begin
          c.mem_rd = 1'b1;
          if (mem_ready) begin
            c.mdr_drv = 1'b1;
            c.dst_ld  = 1'b1;
            c.done    = 1'b1;
          end else begin
            c.hold = 1'b1;
          end
        end
        default: c.done = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bus_step_sequencer.sv
module bus_step_sequencer
  import bss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              mem_ready,
  output logic              pc_drv,
  output logic              tmp_drv,
  output logic              mdr_drv,
  output logic              ir_drv,
  output logic              pc_ld,
  output logic              mar_ld,
  output logic              tmp_ld,
  output logic              ir_ld,
  output logic              dst_ld,
  output logic              alu_inc,
  output logic              mem_rd,
  output logic              instr_done
);
  step_e step_q;
  ctrl_t ctl;

  bss_step_counter u_cnt (
    .clk  (clk),
    .rst  (rst),
    .hold (ctl.hold),
    .done (ctl.done),
    .step (step_q)
  );

  bss_ctrl_decode u_dec (
    .rst       (rst),
    .step      (step_q),
    .mode      (mode),
    .mem_ready (mem_ready),
    .c         (ctl)
  );

  assign pc_drv     = ctl.pc_drv;
  assign tmp_drv    = ctl.tmp_drv;
  assign mdr_drv    = ctl.mdr_drv;
  assign ir_drv     = ctl.ir_drv;
  assign pc_ld      = ctl.pc_ld;
  assign mar_ld     = ctl.mar_ld;
  assign tmp_ld     = ctl.tmp_ld;
  assign ir_ld      = ctl.ir_ld;
  assign dst_ld     = ctl.dst_ld;
  assign alu_inc    = ctl.alu_inc;
  assign mem_rd     = ctl.mem_rd;
  assign instr_done = ctl.done;
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] step_q,
  input logic [1:0] mode,
  input logic       mem_ready,
  input logic       pc_drv,
  input logic       tmp_drv,
  input logic       mdr_drv,
  input logic       ir_drv,
  input logic       pc_ld,
  input logic       mar_ld,
  input logic       tmp_ld,
  input logic       ir_ld,
  input logic       dst_ld,
  input logic       alu_inc,
  input logic       mem_rd,
  input logic       instr_done
);
  logic        in_wait;
  logic [10:0] others;

  assign in_wait = (step_q == 3'd2) || (step_q == 3'd5) || (step_q == 3'd6);
  assign others  = {pc_drv, tmp_drv, mdr_drv, ir_drv, pc_ld, mar_ld,
                    tmp_ld, ir_ld, dst_ld, alu_inc, instr_done};

  always_comb begin
    if (rst) begin
      a_quiet_in_reset_r1: assert ({others, mem_rd} == 12'd0);
    end
  end

  p_reset_step1_r1: assert property (@(posedge clk)
    rst |=> (step_q == 3'd0));

  p_fetch_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    (step_q == 3'd2 && mem_ready) |-> (mdr_drv && ir_ld && mem_rd));

  p_stall_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !mem_ready) |=> $stable(step_q));

  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !mem_ready) |-> (mem_rd && others == 11'd0));

  p_pointer_to_mar_r8: assert property (@(posedge clk) disable iff (rst)
    (step_q == 3'd5 && mode == 2'b10 && mem_ready) |-> (mdr_drv && mar_ld && !dst_ld));

  p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_drv, tmp_drv, mdr_drv, ir_drv}) <= 1);

  p_done_restart_r11: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (!instr_done && step_q == 3'd0));
endmodule

bind bus_step_sequencer bss_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_q     (step_q),
  .mode       (mode),
  .mem_ready  (mem_ready),
  .pc_drv     (pc_drv),
  .tmp_drv    (tmp_drv),
  .mdr_drv    (mdr_drv),
  .ir_drv     (ir_drv),
  .pc_ld      (pc_ld),
  .mar_ld     (mar_ld),
  .tmp_ld     (tmp_ld),
  .ir_ld      (ir_ld),
  .dst_ld     (dst_ld),
  .alu_inc    (alu_inc),
  .mem_rd     (mem_rd),
  .instr_done (instr_done)
);

// File: tb/bus_step_sequencer_bench.sv
`timescale 1ns/1ps
module bus_step_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic       mem_ready = 1'b0;
  logic pc_drv, tmp_drv, mdr_drv, ir_drv, pc_ld, mar_ld, tmp_ld, ir_ld;
  logic dst_ld, alu_inc, mem_rd, instr_done;

  int         n_checks = 0;
  int         n_fails  = 0;
  int         lat      = 0;
  int         rd_cnt   = 0;
  logic [1:0] queued_mode = 2'b00;
  logic       nr_q;
  logic [1:0] nm_q;

  always #2 clk = ~clk;

  bus_step_sequencer u_bus_step_sequencer (
    .clk(clk), .rst(rst), .mode(mode), .mem_ready(mem_ready),
    .pc_drv(pc_drv), .tmp_drv(tmp_drv), .mdr_drv(mdr_drv), .ir_drv(ir_drv),
    .pc_ld(pc_ld), .mar_ld(mar_ld), .tmp_ld(tmp_ld), .ir_ld(ir_ld),
    .dst_ld(dst_ld), .alu_inc(alu_inc), .mem_rd(mem_rd), .instr_done(instr_done)
  );

  task automatic check_eq(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] all_strobes();
    return {pc_drv, tmp_drv, mdr_drv, ir_drv, pc_ld, mar_ld, tmp_ld, ir_ld,
            dst_ld, alu_inc, mem_rd, instr_done};
  endfunction

  // Memory and IR model: ready arrives lat+1 cycles after a read request starts;
  // the mode bits change when the IR is loaded.
  initial forever begin
    @(negedge clk);
    nm_q = mode;
    nr_q = 1'b0;
    if (rst || mdr_drv || !mem_rd) begin
      rd_cnt = 0;
    end else begin
      rd_cnt++;
      nr_q = (rd_cnt > lat);
    end
    if (ir_ld) nm_q = queued_mode;
    @(posedge clk);
    #1;
    mem_ready = nr_q;
    mode      = nm_q;
  end

  // Runs one instruction starting at the negedge of its step-1 cycle.
  task automatic run_instr(string req, logic [1:0] m, int l, int exp_cyc,
                           int exp_mar, int exp_dst, int exp_rdo, logic [31:0] exp_seq);
    int cyc = 0, mar = 0, dst = 0, irl = 0, rdo = 0, multi = 0, badir = 0;
    logic [31:0] seq = 32'h0;
    bit fin = 1'b0;
    queued_mode = m;
    lat = l;
    while (!fin && cyc < 100) begin
      cyc++;
      if (cyc == 1) check_eq("R2 step1 strobes",
        int'(all_strobes()), int'(12'b1000_0110_0100));
      if (cyc == 2) check_eq("R3 step2 strobes",
        int'(all_strobes()), int'(12'b0100_1000_0010));
      if (pc_drv)  seq = (seq << 4) | 32'h1;
      if (tmp_drv) seq = (seq << 4) | 32'h2;
      if (mdr_drv) seq = (seq << 4) | 32'h3;
      if (ir_drv)  seq = (seq << 4) | 32'h4;
      if ((32'(pc_drv) + 32'(tmp_drv) + 32'(mdr_drv) + 32'(ir_drv)) > 1) multi++;
      if (mar_ld) mar++;
      if (dst_ld) dst++;
      if (ir_ld) begin
        irl++;
        if (!(mdr_drv && mem_ready && mem_rd)) badir++;
      end
      if (all_strobes() == 12'b0000_0000_0010) rdo++;
      if (instr_done) fin = 1'b1;
      @(negedge clk);
    end
    check_eq({req, " cycles"}, cyc, exp_cyc);
    check_eq({req, " mar loads"}, mar, exp_mar);
    check_eq({req, " dst loads"}, dst, exp_dst);
    check_eq({req, " bus order"}, int'(seq), int'(exp_seq));
    check_eq("R4 ir loads", irl, 1);
    check_eq("R4 ir load on ready", badir, 0);
    check_eq("R5 read-only cycles", rdo, exp_rdo);
    check_eq("R10 driver overlap", multi, 0);
    check_eq("R11 done one cycle", int'(instr_done), 0);
    check_eq("R11 restart step1", int'(pc_drv && mar_ld && alu_inc), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_eq("R1 quiet in reset", int'(all_strobes()), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_eq("R1 step1 after reset", int'(pc_drv && mar_ld && tmp_ld), 1);
  endtask

  task automatic t_immediate(int l);
    run_instr("R6 immediate", 2'b00, l, 4 + l, 1, 1, l, 32'h1234);
  endtask

  task automatic t_direct(int l);
    run_instr("R7 direct", 2'b01, l, 6 + 2 * l, 2, 1, 1 + 2 * l, 32'h12343);
  endtask

  task automatic t_indirect(int l);
    run_instr("R8 indirect", 2'b10, l, 8 + 3 * l, 3, 1, 2 + 3 * l, 32'h123433);
  endtask

  task automatic t_noop(int l);
    run_instr("R9 no-op", 2'b11, l, 4 + l, 1, 0, l, 32'h123);
  endtask

  task automatic t_reset_in_stall();
    queued_mode = 2'b01;
    lat = 6;
    repeat (4) @(negedge clk);
    check_eq("R5 stalled read only", int'(all_strobes()), int'(12'b0000_0000_0010));
    @(posedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    check_eq("R1 quiet in mid reset", int'(all_strobes()), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_eq("R1 restart after mid reset", int'(pc_drv && mar_ld && alu_inc), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_immediate(0);
    t_direct(0);
    t_indirect(0);
    t_noop(0);
    t_immediate(3);
    t_direct(1);
    t_indirect(2);
    t_noop(2);
    t_indirect(1);
    t_immediate(1);
    t_reset_in_stall();
    t_direct(2);
    t_immediate(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule